// File: doc/BRIEF.md
# Up-Counting Timer Time Base with Repetition Gating

This block is the time base of a general-purpose timer. A prescaler divides the input clock by a programmable amount. Each prescaler tick advances a 16-bit up-counter. The counter runs from zero up to a programmable period and then returns to zero. Each return to zero is a wrap. An 8-bit repetition down-counter decides which wraps are reported. With a repetition value of N, only every (N+1)-th wrap produces the overflow event pulse and sets the sticky overflow flag.

Software programs the block through a simple write port with one strobe, a 2-bit address and a 16-bit data word. This port loads the divider, the period and the repetition value. It also sets the run and period-buffer controls and clears the flag. With buffering off, a new period takes effect at once. With buffering on, a new period waits in a holding register and becomes active at the next wrap. The block drives the live count, a one-cycle event pulse and the flag.

Top module: `timer_rep_base`

## Requirements
- R1: While running, the count increases by one on every prescaler tick until it equals the active period. The next tick returns it to 0, which is a wrap.
- R2: With divider value D, the counter advances once every D+1 clock cycles.
- R3: A write occurs on a clock edge with `wr_en` high. Address 0 is control: bit 0 is run enable, bit 1 is period buffering, and bit 2 set to 1 clears the flag. Address 1 is the divider, address 2 is the period and address 3 is the repetition value.
- R4: With a repetition value of 0, every wrap raises `ovf_pulse` for exactly one cycle, in the same cycle that `count` shows 0.
- R5: With a repetition value of N, the event occurs on every (N+1)-th wrap. Writing the repetition value reloads the down-counter with it.
- R6: `ovf_flag` is set together with each event and stays set until a clear is written.
- R7: When an event and a clear fall on the same clock edge, the flag ends up set.
- R8: With buffering off, a written period becomes active at once and ends the current count sequence.
- R9: With buffering on, a written period becomes active only at the next wrap. The current sequence still runs to the old period.
- R10: With run enable low, the count and the prescaler hold their values. Setting run enable again resumes counting from the held count.
- R11: After reset, the count is 0, the pulse and the flag are low, and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 divider, 2 period, 3 repetition) |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| ovf_pulse | output | 1 | One-cycle overflow event |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that the divider and the period are never both zero while the block runs. In that case every clock would be a wrap and the pulse could stay high. They also assume that a clear comes only through a control write with bit 2 set. The stimulus never programs a zero period with a zero divider, and it always writes the control word with the intended run and buffer bits, so a clear never stops the counter by accident. Period changes are made while the count is below both the old and the new period, so the order of wraps stays easy to predict.

// File: rtl/tmr_pkg.sv
// Shared definitions for the timer time base: register addresses and
// control-word bit positions. Assumes a 2-bit register address.
package tmr_pkg;
    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_DIV  = 2'd1,
        ADDR_PER  = 2'd2,
        ADDR_REP  = 2'd3
    } tmr_addr_e;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_BUF_BIT = 1;
    localparam int CTRL_CLR_BIT = 2;
endpackage

// File: rtl/tmr_prescaler.sv
// Clock prescaler: emits one tick every div+1 cycles while run is high.
// Assumes div may change at any time; a count already past the new div
// ticks at once instead of wrapping through the whole range.
module tmr_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] pcnt;

    // Tick when the divide count reaches the divider value.
    always_comb tick = run && (pcnt >= div);

    // Advance or restart the divide count; hold it while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (run)
            pcnt <= tick ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/tmr_count_unit.sv
// Up-counter with an active period and a holding register for the period.
// Unbuffered writes update the active period at once. Buffered writes
// reach it at the next wrap. Assumes ticks come only from the prescaler.
module tmr_count_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         buf_en,
    input  logic         per_wr,
    input  logic [W-1:0] per_data,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic [W-1:0] per_hold;
    logic [W-1:0] per_act;

    // A wrap is a tick taken at or beyond the active period.
    always_comb wrap = tick && (count >= per_act);

    // Step or clear the count on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (tick)
            count <= wrap ? '0 : count + 1'b1;
    end

    // Keep the holding and active period registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_hold <= '0;
            per_act  <= '0;
        end else begin
            if (wrap && buf_en)
                per_act <= per_hold;
            if (per_wr) begin
                per_hold <= per_data;
                if (!buf_en)
                    per_act <= per_data;
            end
        end
    end
endmodule

// File: rtl/tmr_repeat_unit.sv
// Repetition gate: counts wraps down from the repetition value and
// reports an event when a wrap finds the down-counter at zero. It also
// keeps the sticky flag. Assumes clr is a one-cycle strobe.
module tmr_repeat_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wrap,
    input  logic [W-1:0] rep_val,
    input  logic         rep_wr,
    input  logic [W-1:0] rep_data,
    input  logic         clr,
    output logic         evt_pulse,
    output logic         flag
);
    logic [W-1:0] rcnt;
    logic         evt;

    // An event is a wrap taken with the down-counter exhausted.
    always_comb evt = wrap && (rcnt == '0);

    // Reload on a write or an event; otherwise count wraps down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rcnt <= '0;
        else if (rep_wr)
            rcnt <= rep_data;
        else if (wrap)
            rcnt <= (rcnt == '0) ? rep_val : rcnt - 1'b1;
    end

    // Register the pulse. The flag sets on an event, and an event beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_pulse <= 1'b0;
            flag      <= 1'b0;
        end else begin
            evt_pulse <= evt;
            flag      <= evt | (flag & ~clr);
        end
    end
endmodule

// File: rtl/timer_rep_base.sv
// Timer time base top: holds the control, divider and repetition
// registers, decodes writes, and joins the prescaler, the counter and
// the repetition gate. Assumes one write per cycle at most.
module timer_rep_base #(
    parameter int DIV_W = 16,
    parameter int PER_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [15:0]      wr_data,
    output logic [PER_W-1:0] count,
    output logic             ovf_pulse,
    output logic             ovf_flag
);
    import tmr_pkg::*;

    logic             en_q;
    logic             buf_q;
    logic [DIV_W-1:0] div_q;
    logic [REP_W-1:0] rep_q;
    logic             ctrl_wr, div_wr, per_wr, rep_wr, clr_strobe;
    logic             tick, wrap;

    // Decode the write strobe into per-register selects.
    always_comb begin
        ctrl_wr    = wr_en && (wr_addr == ADDR_CTRL);
        div_wr     = wr_en && (wr_addr == ADDR_DIV);
        per_wr     = wr_en && (wr_addr == ADDR_PER);
        rep_wr     = wr_en && (wr_addr == ADDR_REP);
        clr_strobe = ctrl_wr && wr_data[CTRL_CLR_BIT];
    end

    // Hold the control, divider and repetition registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            buf_q <= 1'b0;
            div_q <= '0;
            rep_q <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q  <= wr_data[CTRL_RUN_BIT];
                buf_q <= wr_data[CTRL_BUF_BIT];
            end
            if (div_wr) div_q <= wr_data[DIV_W-1:0];
            if (rep_wr) rep_q <= wr_data[REP_W-1:0];
        end
    end

    tmr_prescaler #(.W(DIV_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(en_q), .div(div_q), .tick(tick)
    );

    tmr_count_unit #(.W(PER_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .buf_en(buf_q),
        .per_wr(per_wr), .per_data(wr_data[PER_W-1:0]),
        .count(count), .wrap(wrap)
    );

    tmr_repeat_unit #(.W(REP_W)) u_rep (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .rep_val(rep_q),
        .rep_wr(rep_wr), .rep_data(wr_data[REP_W-1:0]), .clr(clr_strobe),
        .evt_pulse(ovf_pulse), .flag(ovf_flag)
    );
endmodule

// File: rtl/timer_rep_base_chk.sv
// Property checker for the timer time base, bound into every instance.
// Assumes the divider and the period are not both zero while running.
module timer_rep_base_chk #(
    parameter int PER_W = 16,
    parameter int REP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PER_W-1:0] count,
    input logic             ovf_pulse,
    input logic             ovf_flag,
    input logic             clr_strobe,
    input logic             tick,
    input logic             wrap,
    input logic             en_q,
    input logic [REP_W-1:0] rcnt
);
    // R1: a tick that does not wrap moves the count up by one
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> (count == $past(count) + 1'b1));

    // R4: the event pulse appears with the count at zero
    p_pulse_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count == '0));

    // R5: a wrap with repetitions left produces no event
    p_rep_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && (rcnt != '0)) |=> !ovf_pulse);

    // R6: the flag is up whenever the pulse is
    p_flag_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ovf_flag);

    // R6: without a clear, the flag stays set
    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_strobe) |=> ovf_flag);

    // R10: when stopped, the count does not move
    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> $stable(count));
endmodule

bind timer_rep_base timer_rep_base_chk #(.PER_W(PER_W), .REP_W(REP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .count(count), .ovf_pulse(ovf_pulse),
    .ovf_flag(ovf_flag), .clr_strobe(clr_strobe), .tick(tick), .wrap(wrap),
    .en_q(en_q), .rcnt(u_rep.rcnt)
);

// File: tb/tb_timer_rep_base.sv
// Directed bench for the timer time base: one task per scenario.
module tb_timer_rep_base;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        ovf_pulse;
    logic        ovf_flag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    timer_rep_base dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .ovf_pulse(ovf_pulse),
        .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Control word: bit0 run, bit1 buffer, bit2 clear
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pulse();
        for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk);
            if (ovf_pulse) return;
        end
        check("timeout waiting for pulse", 0, 1);
    endtask

    task automatic wait_count(input int v);
        for (int i = 0; i < LIMIT; i++) begin
            if (count == v) return;
            @(negedge clk);
        end
        check("timeout waiting for count", int'(count), v);
    endtask

    task automatic measure(output int n);
        wait_pulse();
        n = 0;
        for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk);
            n++;
            if (ovf_pulse) return;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11 count", int'(count), 0);
        check("R11 pulse", int'(ovf_pulse), 0);
        check("R11 flag", int'(ovf_flag), 0);
        repeat (5) @(negedge clk);
        check("R11 stopped count", int'(count), 0);
    endtask

    task automatic t_basic();
        int n, w;
        wr(2'd1, 16'd0); wr(2'd2, 16'd4); wr(2'd3, 16'd0); wr(2'd0, 16'h1);
        measure(n);
        check("R1 R4 wrap interval P=4", n, 5);
        wait_pulse();
        check("R4 count zero with pulse", int'(count), 0);
        @(negedge clk);
        check("R4 pulse one cycle", int'(ovf_pulse), 0);
        w = 0;
        wait_count(4);
        check("R1 count reaches period", int'(count), 4);
        @(negedge clk);
        check("R1 count returns to zero", int'(count), 0);
    endtask

    task automatic t_prescale();
        int n;
        wr(2'd1, 16'd2); wr(2'd2, 16'd3);
        measure(n); measure(n);
        check("R2 R3 divided interval D=2 P=3", n, 12);
        wr(2'd1, 16'd0);
    endtask

    task automatic t_repeat();
        int n;
        wr(2'd2, 16'd4); wr(2'd3, 16'd2);
        measure(n); measure(n);
        check("R5 event every third wrap", n, 15);
        wr(2'd3, 16'd0);
        measure(n); measure(n);
        check("R5 back to every wrap", n, 5);
    endtask

    task automatic t_flag();
        int n;
        wr(2'd2, 16'd4); wr(2'd3, 16'd3);
        wait_pulse();
        repeat (10) @(negedge clk);
        check("R6 flag sticky", int'(ovf_flag), 1);
        wait_count(1);
        wr(2'd0, 16'h5);
        check("R6 flag cleared", int'(ovf_flag), 0);
        wr(2'd3, 16'd0);
        measure(n);
        wait_count(4);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h5;
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 pulse at collision", int'(ovf_pulse), 1);
        check("R7 event wins over clear", int'(ovf_flag), 1);
    endtask

    task automatic t_period_direct();
        int mx;
        wr(2'd0, 16'h1); wr(2'd2, 16'd9);
        wait_pulse();
        wait_count(3);
        wr(2'd2, 16'd5);
        mx = 0;
        for (int i = 0; i < LIMIT; i++) begin
            if (ovf_pulse) break;
            if (int'(count) > mx) mx = int'(count);
            @(negedge clk);
        end
        check("R8 new period immediate", mx, 5);
    endtask

    task automatic t_period_buffered();
        int mx, n;
        wr(2'd2, 16'd9);
        wr(2'd0, 16'h3);
        wait_pulse();
        wait_count(3);
        wr(2'd2, 16'd5);
        mx = 0;
        for (int i = 0; i < LIMIT; i++) begin
            if (ovf_pulse) break;
            if (int'(count) > mx) mx = int'(count);
            @(negedge clk);
        end
        check("R9 old period kept", mx, 9);
        measure(n);
        check("R9 new period after wrap", n, 6);
        wr(2'd0, 16'h1);
    endtask

    task automatic t_freeze();
        int c0;
        wr(2'd1, 16'd3); wr(2'd2, 16'd50);
        wait_pulse();
        repeat (20) @(negedge clk);
        wr(2'd0, 16'h0);
        c0 = int'(count);
        repeat (20) @(negedge clk);
        check("R10 count frozen", int'(count), c0);
        wr(2'd0, 16'h1);
        for (int i = 0; i < 20; i++) begin
            if (int'(count) != c0) break;
            @(negedge clk);
        end
        check("R10 resumes from held count", int'(count), c0 + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_prescale();
        t_repeat();
        t_flag();
        t_period_direct();
        t_period_buffered();
        t_freeze();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule